// File: doc/BRIEF.md
# Multi-Mode Event Scaler

The block counts rising edges on 32 independent pulse inputs. A load strobe, the event marker, freezes a snapshot of all counters at once. Software reaches the block through a 32-bit register port with word addresses. A mode field picks what happens to each snapshot. In latching mode the snapshot sits in a bank of readable shadow words. In multichannel mode the snapshot is also drained into a readout FIFO, one word per clock, in ascending channel order. A per-channel skip mask controls which channels are drained.

Counting begins only after a start key is written. Three key addresses act on any write to them, whatever the data: start, full reset and FIFO flush. An optional clear-on-event setting zeroes the counters at every accepted load strobe, which turns the scaler into a per-event counter. A global inhibit input freezes every channel.

Word addresses equal the byte offset divided by four. The register map is: control/status at word 0x000, mode at word 0x040, skip mask at word 0x041, reset key at word 0x100, FIFO flush key at word 0x101, start key at word 0x106, and shadow words at 0x200 plus the channel number. The FIFO window is any word address with bit 21 set, which is byte offset 0x800000 and up. Read data appears on `reg_rdata` one clock after `reg_rd`.

Top module: `mm_event_scaler`

## Requirements
- R1: After reset, the control/status word reads 0x00002000 (only the FIFO-empty flag set). The mode word and the skip-mask word read 0.
- R2: Once started by any write to the start key (word 0x106), each channel adds one for every rising edge of its input. A rising edge is a cycle where the input is high and it was low in the cycle before.
- R3: While `inhibit_in` is high, no counter advances.
- R4: Before the first start key write, input edges are not counted and load strobes are ignored. No snapshot is taken and nothing enters the FIFO.
- R5: The mode word holds the mode in bits [30:28]. Any mode value other than 2 selects latching mode. In latching mode, an accepted load-strobe rising edge copies every counter into shadow word 0x200+channel. When bit 0 of the mode word is 0, the counters keep their values.
- R6: When bit 0 of the mode word is 1, every accepted load strobe restarts all counters from zero after the snapshot is taken.
- R7: A count edge in the same cycle as an accepted load strobe is excluded from that snapshot. It is still counted: the counter reads 1 after a clearing event, or the old value plus one otherwise.
- R8: In mode 2, an accepted load strobe also pushes the snapshot words of every channel whose skip-mask bit is 0. The words go in ascending channel order, one per clock, starting the clock after the strobe. Each read of the FIFO window pops one word.
- R9: A read of the FIFO window while the FIFO is empty returns 0 and does not disturb any later data.
- R10: The FIFO holds 64 words. A push into a full FIFO is dropped and sets a sticky overflow flag (control/status bit 14). Any write to the flush key (word 0x101) empties the FIFO, which sets the empty flag (bit 13), and clears the overflow flag.
- R11: Any write to the reset key (word 0x100) puts every register, counter, shadow word and the FIFO back into the state they have after reset, including the not-started state.
- R12: In the control/status word, write data bits [7:0] set control bits [7:0] and write data bits [23:16] clear them. Clear wins over set, so writing 0xFFFF0000 clears all control bits. Readback is: [7:0] control, [12] capture busy, [13] FIFO empty, [14] overflow, [15] running.
- R13: A load strobe that arrives while a multichannel capture is still draining is ignored completely: no snapshot, no counter clear and no extra FIFO words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_in | input | 32 | Per-channel count inputs; rising edges are counted |
| lne_in | input | 1 | Load strobe (event marker); its rising edge takes a snapshot |
| inhibit_in | input | 1 | Freezes all counters while high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 22 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one clock after `reg_rd` |

## Verification
Two kinds of same-cycle collision matter here. The first is a count edge and an accepted load strobe in the same clock. The bench drives channel 0 and the strobe high on the same edge, in both clearing and non-clearing modes. It then checks that the shadow word holds the old value. A second strobe then shows the coincident edge in the counter, as 1 after a clear or old value plus one otherwise. The second collision is a new load strobe landing while a multichannel drain is still running. The bench sends one a few clocks after the first and judges it by the FIFO holding exactly one event's worth of words.

// File: rtl/scaler_pkg.sv
// Package: shared word addresses and mode codes for the event scaler.
// Assumes word addressing (byte offset / 4).
package scaler_pkg;
    localparam int unsigned WA_CSR       = 'h000;
    localparam int unsigned WA_MODE      = 'h040;
    localparam int unsigned WA_MASK      = 'h041;
    localparam int unsigned WA_KEY_RST   = 'h100;
    localparam int unsigned WA_KEY_FLUSH = 'h101;
    localparam int unsigned WA_KEY_START = 'h106;
    localparam int unsigned WA_SHADOW    = 'h200;

    localparam logic [2:0] MODE_MCS = 3'd2;

    // status bit positions in the control/status readback
    localparam int unsigned ST_BUSY    = 12;
    localparam int unsigned ST_EMPTY   = 13;
    localparam int unsigned ST_OVF     = 14;
    localparam int unsigned ST_RUNNING = 15;
endpackage

// File: rtl/scaler_cnt_bank.sv
// Counter bank: one edge-detected counter and one shadow word per channel.
// Assumes count inputs are synchronous; a snapshot takes the value before
// any edge of the same cycle, and a clearing snapshot keeps that edge.
module scaler_cnt_bank #(
    parameter int NCH = 32,
    parameter int DW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          cnt_in,
    input  logic                    count_en,
    input  logic                    snap_fire,
    input  logic                    clr_mode,
    output logic [NCH-1:0][DW-1:0]  shadow_o
);
    logic [NCH-1:0] prev_q;

    // track previous level of every count input for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cnt_in;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [DW-1:0] cnt_q;
        logic          inc;

        assign inc = count_en & cnt_in[ch] & ~prev_q[ch];

        // advance counter, take snapshot, optionally restart on event
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q       <= '0;
                shadow_o[ch] <= '0;
            end else if (snap_fire) begin
                shadow_o[ch] <= cnt_q;
                cnt_q        <= clr_mode ? DW'(inc) : cnt_q + DW'(inc);
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (!count_en && !(snap_fire && clr_mode)) |=> $stable(cnt_q)); // R3
    end
endmodule

// File: rtl/scaler_mcs_fifo.sv
// Multichannel capture: walks the unmasked channels of a snapshot in
// ascending order, one per clock, into a readout FIFO with sticky overflow.
// Assumes the snapshot stays stable while busy (caller blocks new events).
module scaler_mcs_fifo #(
    parameter int NCH   = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0][DW-1:0]  snap_i,
    input  logic [NCH-1:0]          skip_mask,
    input  logic                    cap_start,
    input  logic                    flush,
    input  logic                    pop,
    output logic [DW-1:0]           head_o,
    output logic                    empty_o,
    output logic                    ovf_o,
    output logic                    busy_o
);
    localparam int IW = $clog2(NCH);
    localparam int PW = $clog2(DEPTH);

    logic [NCH-1:0] pend_q;
    logic [IW-1:0]  sel_idx;
    logic [DW-1:0]  mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [PW:0]    fill;
    logic           full, push_ok, pop_ok;

    assign busy_o  = |pend_q;
    assign full    = (fill == (PW+1)'(DEPTH));
    assign empty_o = (fill == '0);
    assign push_ok = busy_o & ~full;
    assign pop_ok  = pop & ~empty_o;
    assign head_o  = mem[rd_ptr];

    // pick the lowest pending channel
    always_comb begin
        sel_idx = '0;
        for (int i = NCH-1; i >= 0; i--)
            if (pend_q[i]) sel_idx = IW'(i);
    end

    // load pending set on an event, retire one channel per clock
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= '0;
        else if (cap_start)  pend_q <= ~skip_mask;
        else if (busy_o)     pend_q[sel_idx] <= 1'b0;
    end

    // FIFO storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= snap_i[sel_idx];
    end

    // FIFO pointers, fill level and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            ovf_o  <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + (PW+1)'(push_ok) - (PW+1)'(pop_ok);
            if (busy_o && full) ovf_o <= 1'b1;
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (PW+1)'(DEPTH)); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flush) |=> ovf_o); // R10
    AST_ONE_PER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($countones(pend_q) == $past($countones(pend_q)) - 1)); // R13
endmodule

// File: rtl/mm_event_scaler.sv
// Top: register decode, key actions, load-strobe edge detection and the
// read mux. Assumes single-cycle synchronous strobes and word addresses.
module mm_event_scaler #(
    parameter int NCH        = 32,
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int AW         = 22
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cnt_in,
    input  logic           lne_in,
    input  logic           inhibit_in,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata
);
    import scaler_pkg::*;

    localparam int SIW = $clog2(NCH);
    localparam logic [AW-1:0] SH_BASE = AW'(WA_SHADOW);

    logic                   rst_int_n;
    logic                   started_q, lne_prev_q, lne_fire, mcs_sel;
    logic [2:0]             mode_q;
    logic                   clr_q;
    logic [NCH-1:0]         mask_q;
    logic [7:0]             ctrl_q;
    logic [NCH-1:0][DW-1:0] shadow;
    logic [DW-1:0]          fifo_head, rd_mux;
    logic                   fifo_empty, fifo_ovf, fifo_busy;
    logic                   fifo_win, sh_hit, key_flush, pop;
    logic                   unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign rst_int_n = rst_n & ~(reg_wr && reg_addr == AW'(WA_KEY_RST));
    assign key_flush = reg_wr && reg_addr == AW'(WA_KEY_FLUSH);
    assign fifo_win  = reg_addr[AW-1];
    assign sh_hit    = reg_addr[AW-1:SIW] == SH_BASE[AW-1:SIW];
    assign pop       = reg_rd & fifo_win;
    assign mcs_sel   = (mode_q == MODE_MCS);
    assign lne_fire  = lne_in & ~lne_prev_q & started_q & ~fifo_busy;

    // load-strobe edge tracking
    always_ff @(posedge clk) begin
        if (!rst_int_n) lne_prev_q <= 1'b0;
        else            lne_prev_q <= lne_in;
    end

    // configuration registers and start key
    always_ff @(posedge clk) begin
        if (!rst_int_n) begin
            started_q <= 1'b0;
            mode_q    <= '0;
            clr_q     <= 1'b0;
            mask_q    <= '0;
            ctrl_q    <= '0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(WA_KEY_START)) started_q <= 1'b1;
            if (reg_addr == AW'(WA_MODE)) begin
                mode_q <= reg_wdata[30:28];
                clr_q  <= reg_wdata[0];
            end
            if (reg_addr == AW'(WA_MASK)) mask_q <= reg_wdata[NCH-1:0];
            if (reg_addr == AW'(WA_CSR))
                ctrl_q <= (ctrl_q | reg_wdata[7:0]) & ~reg_wdata[23:16];
        end
    end

    scaler_cnt_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .cnt_in    (cnt_in),
        .count_en  (started_q & ~inhibit_in),
        .snap_fire (lne_fire),
        .clr_mode  (clr_q),
        .shadow_o  (shadow)
    );

    scaler_mcs_fifo #(.NCH(NCH), .DW(DW), .DEPTH(FIFO_DEPTH)) u_cap (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .snap_i    (shadow),
        .skip_mask (mask_q),
        .cap_start (lne_fire & mcs_sel),
        .flush     (key_flush),
        .pop       (pop),
        .head_o    (fifo_head),
        .empty_o   (fifo_empty),
        .ovf_o     (fifo_ovf),
        .busy_o    (fifo_busy)
    );

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (fifo_win) begin
            if (!fifo_empty) rd_mux = fifo_head;
        end else if (sh_hit) begin
            rd_mux = shadow[reg_addr[SIW-1:0]];
        end else if (reg_addr == AW'(WA_CSR)) begin
            rd_mux[7:0]        = ctrl_q;
            rd_mux[ST_BUSY]    = fifo_busy;
            rd_mux[ST_EMPTY]   = fifo_empty;
            rd_mux[ST_OVF]     = fifo_ovf;
            rd_mux[ST_RUNNING] = started_q;
        end else if (reg_addr == AW'(WA_MODE)) begin
            rd_mux[30:28] = mode_q;
            rd_mux[0]     = clr_q;
        end else if (reg_addr == AW'(WA_MASK)) begin
            rd_mux[NCH-1:0] = mask_q;
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_int_n)  reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
        (reg_rd && fifo_win && fifo_empty) |=> (reg_rdata == '0)); // R9
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
        !started_q |=> !fifo_busy); // R4
endmodule

// File: tb/mm_event_scaler_bench.sv
module mm_event_scaler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt_in = '0;
    logic        lne_in = 1'b0, inhibit_in = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [21:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [31:0] mdl [32];
    logic [31:0] snap [32];

    localparam logic [21:0] A_CSR = 22'h000, A_MODE = 22'h040, A_MASK = 22'h041,
        A_RST = 22'h100, A_FLUSH = 22'h101, A_START = 22'h106,
        A_SH = 22'h200, A_FIFO = 22'h200000;

    // {mode[2:0], clear, seed[3:0], skip_mask[31:0]}
    localparam logic [39:0] VEC [6] = '{
        40'h0_1_00000000, 40'h1_2_00000000, 40'h4_3_00000000,
        40'h4_1_FFFFFFBB, 40'h5_2_0FFFFFFF, 40'hA_3_00000000 };

    mm_event_scaler u_mm_event_scaler (.*);

    always #2 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [21:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(logic [21:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic lne(bit clr);
        @(negedge clk); lne_in = 1;
        @(negedge clk); lne_in = 0;
        for (int c = 0; c < 32; c++) begin
            snap[c] = mdl[c];
            if (clr) mdl[c] = 0;
        end
    endtask

    task automatic pulses(int seed, bit counts);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            for (int c = 0; c < 32; c++) begin
                cnt_in[c] = (((c + 1) * seed) % 5) > k;
                if (cnt_in[c] && counts) mdl[c] = mdl[c] + 1;
            end
            @(negedge clk); cnt_in = '0;
        end
    endtask

    task automatic zero_model();
        for (int c = 0; c < 32; c++) mdl[c] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        zero_model();
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(A_CSR, d);  chk("R1 csr", d, 32'h2000);
        rd(A_MODE, d); chk("R1 mode", d, 0);
        rd(A_MASK, d); chk("R1 mask", d, 0);

        // R4: edges and strobes before start
        wr(A_MODE, 32'h2000_0000);
        pulses(3, 0);
        lne(0);
        repeat (40) @(negedge clk);
        rd(A_CSR, d); chk("R4 no capture", d, 32'h2000);
        wr(A_START, 32'h0);
        wr(A_MODE, 32'h0);
        lne(0);
        rd(A_SH + 7, d); chk("R4 no count", d, 0);

        // table walk: R2 R5 R6 R8 R9
        foreach (VEC[i]) begin
            logic [2:0]  md;
            logic        cl;
            logic [31:0] mk;
            md = VEC[i][39:37]; cl = VEC[i][36]; mk = VEC[i][31:0];
            wr(A_MODE, {1'b0, md, 27'b0, cl});
            wr(A_MASK, mk);
            pulses(int'(VEC[i][35:32]), 1);
            lne(cl);
            repeat (40) @(negedge clk);
            if (md == 3'd2) begin
                for (int c = 0; c < 32; c++)
                    if (!mk[c]) begin
                        rd(A_FIFO, d); chk("R8 fifo word", d, snap[c]);
                    end
                rd(A_FIFO, d); chk("R9 empty read", d, 0);
            end else begin
                for (int c = 0; c < 32; c++) begin
                    rd(A_SH + 22'(c), d);
                    chk(cl ? "R6 shadow" : "R5 R2 shadow", d, snap[c]);
                end
            end
        end

        // R11: reset key
        wr(A_RST, 32'h1234);
        zero_model();
        rd(A_MODE, d);   chk("R11 mode", d, 0);
        rd(A_CSR, d);    chk("R11 csr", d, 32'h2000);
        rd(A_SH + 3, d); chk("R11 shadow", d, 0);
        wr(A_START, 32'hFFFF);

        // R3: inhibit
        inhibit_in = 1;
        repeat (3) begin
            @(negedge clk); cnt_in[5] = 1; @(negedge clk); cnt_in[5] = 0;
        end
        inhibit_in = 0;
        lne(0);
        rd(A_SH + 5, d); chk("R3 inhibited", d, 0);
        repeat (2) begin
            @(negedge clk); cnt_in[5] = 1; @(negedge clk); cnt_in[5] = 0;
        end
        lne(0);
        rd(A_SH + 5, d); chk("R3 resumed", d, 2);

        // R7: count edge coinciding with snapshot
        @(negedge clk); cnt_in[0] = 1; @(negedge clk); cnt_in[0] = 0;
        @(negedge clk); cnt_in[0] = 1; lne_in = 1;
        @(negedge clk); cnt_in[0] = 0; lne_in = 0;
        rd(A_SH, d); chk("R7 excluded", d, 1);
        lne(0);
        rd(A_SH, d); chk("R7 kept", d, 2);
        wr(A_MODE, 32'h1);
        @(negedge clk); cnt_in[0] = 1; lne_in = 1;
        @(negedge clk); cnt_in[0] = 0; lne_in = 0;
        rd(A_SH, d); chk("R7 clr excluded", d, 2);
        lne(1);
        rd(A_SH, d); chk("R7 clr kept", d, 1);
        lne(1);
        rd(A_SH, d); chk("R6 cleared", d, 0);

        // R13: second strobe during drain
        wr(A_MODE, 32'h2000_0000);
        wr(A_MASK, 32'h0);
        lne(0);
        repeat (3) @(negedge clk);
        lne(0);
        repeat (40) @(negedge clk);
        for (int c = 0; c < 32; c++) begin
            rd(A_FIFO, d); chk("R13 words", d, 0);
        end
        rd(A_CSR, d); chk("R13 only one event", d & 32'h2000, 32'h2000);

        // R10: overflow and flush
        repeat (3) begin
            lne(0);
            repeat (40) @(negedge clk);
        end
        rd(A_CSR, d); chk("R10 overflow", d & 32'h6000, 32'h4000);
        wr(A_FLUSH, 32'h0);
        rd(A_CSR, d); chk("R10 flushed", d & 32'h6000, 32'h2000);

        // R12: control bits set/clear
        wr(A_CSR, 32'h0000_00A5);
        rd(A_CSR, d); chk("R12 set", d & 32'hFF, 32'hA5);
        wr(A_CSR, 32'h0001_0002);
        rd(A_CSR, d); chk("R12 set clr", d & 32'hFF, 32'hA6);
        wr(A_CSR, 32'h0004_0004);
        rd(A_CSR, d); chk("R12 clear wins", d & 32'hFF, 32'hA2);
        wr(A_CSR, 32'hFFFF_0000);
        rd(A_CSR, d); chk("R12 clear all", d & 32'hFF, 32'h00);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule